// File: doc/BRIEF.md
# I2C Master Interrupt and Abort Status Unit

This block sits beside an I2C master engine and turns the engine's single-cycle event pulses into sticky interrupt status. Twelve event sources each own one bit of a raw status word. A software-written enable mask selects which raw bits may interrupt the host, and the OR of the enabled bits drives one interrupt line.

Software clears status by reading. Each source has its own read-to-clear address, and one further address clears every bit at once. When the engine gives up a transfer, it pulses the abort event and presents a cause vector. The unit accumulates that vector into a cause word and requests a flush of both data FIFOs. Reading the abort source's clear address, or the global clear address, wipes the cause word. Software therefore reads the cause word before it clears the abort.

Access goes through a single-cycle register port. Read data is combinational in the cycle of `rd_en`. The clear side effects take hold at the clock edge that ends that cycle.

Top module: `i2cm_irq_ctrl`

## Requirements
- R1: After reset the enable mask, raw status and cause word read as zero, and `irq_o` and `flush_o` are low.
- R2: A pulse on `evt_i[k]` sets raw bit k at the next edge, and the bit stays set until cleared. Bit order: 0 tx-empty, 1 tx-over, 2 rx-full, 3 rx-over, 4 rx-under, 5 rx-done, 6 read-request, 7 abort, 8 activity, 9 start-seen, 10 stop-seen, 11 general-call.
- R3: Writing address 0 loads the enable mask from `wdata`. Writes to any other address have no effect. Address 0 reads the mask, address 1 reads raw status, and address 2 reads raw AND mask.
- R4: Reading address 16+k returns raw bit k in bit 0 and clears only raw bit k.
- R5: If an event on bit k arrives in the same cycle as a clear of bit k (per-source or global), bit k stays set.
- R6: Reading address 4 returns the raw word and clears all raw bits, except those raised by an event in the same cycle. It also wipes the cause word.
- R7: The cause vector is ORed into the cause word only in cycles where the abort event (bit 7) pulses. Bits accumulate across aborts, and address 3 reads the word. Cause bit order: 0 arbitration lost, 1 7-bit address NACK, 2 10-bit first address byte NACK, 3 10-bit second address byte NACK, 4 data NACK, 5 general-call NACK, 6 read after general call, 7 start byte acknowledged, 8 start byte with restart off, 9 10-bit read with restart off, 10 use while disabled.
- R8: Reading address 23 (the abort source's clear address) zeroes the cause word. Cause bits arriving with an abort in that same cycle are kept.
- R9: `flush_o` is high for exactly the cycle after each cycle in which the abort event pulses.
- R10: `irq_o` equals, one cycle later, the OR of raw AND mask.
- R11: `rdata` is zero when `rd_en` is low or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Event pulses from the engine, one per source |
| abrt_cause_i | input | NUM_CAUSE | Abort cause vector, qualified by the abort event |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | NUM_SRC | Write data (mask) |
| rdata | output | max(NUM_SRC,NUM_CAUSE) | Read data, valid in the read cycle |
| irq_o | output | 1 | Combined interrupt |
| flush_o | output | 1 | FIFO flush request after an abort |

## Verification
The two functions that can fall in the same cycle are a new event or abort cause from the engine and a clearing read from software. The clearing read may be a per-source clear, the global clear, or the cause wipe.

Directed cycles drive an event on bit k together with a read of that bit's clear address. They also drive a global clear while a different source fires, and an abort with fresh cause bits in the cycle that reads the abort clear address.

A random phase then mixes sparse events, reads and mask writes. On every clock a behavioural model judges the read data, `irq_o` and `flush_o`; in that model an arriving event or cause always outranks a clear.

// File: rtl/i2cm_irq_pkg.sv
package i2cm_irq_pkg;
   // event source bit positions in the raw status word
   localparam int SRC_TX_EMPTY  = 0;
   localparam int SRC_TX_OVER   = 1;
   localparam int SRC_RX_FULL   = 2;
   localparam int SRC_RX_OVER   = 3;
   localparam int SRC_RX_UNDER  = 4;
   localparam int SRC_RX_DONE   = 5;
   localparam int SRC_RD_REQ    = 6;
   localparam int SRC_TX_ABRT   = 7;
   localparam int SRC_ACTIVITY  = 8;
   localparam int SRC_START_DET = 9;
   localparam int SRC_STOP_DET  = 10;
   localparam int SRC_GEN_CALL  = 11;
   localparam int SRC_COUNT     = 12;

   // abort cause bit positions
   localparam int CZ_ARB_LOST      = 0;
   localparam int CZ_ADDR7_NACK    = 1;
   localparam int CZ_ADDR10A_NACK  = 2;
   localparam int CZ_ADDR10B_NACK  = 3;
   localparam int CZ_DATA_NACK     = 4;
   localparam int CZ_GCALL_NACK    = 5;
   localparam int CZ_GCALL_READ    = 6;
   localparam int CZ_SBYTE_ACK     = 7;
   localparam int CZ_SBYTE_NORST   = 8;
   localparam int CZ_RD10_NORST    = 9;
   localparam int CZ_DISABLED_USE  = 10;
   localparam int CAUSE_COUNT      = 11;

   // register map
   localparam int ADR_MASK     = 0;
   localparam int ADR_RAW      = 1;
   localparam int ADR_MSTAT    = 2;
   localparam int ADR_CAUSE    = 3;
   localparam int ADR_CLR_ALL  = 4;
   localparam int ADR_CLR_BASE = 16;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] clr_i,
   input  logic         clr_all_i,
   output logic [N-1:0] raw_o
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)                        bit_q <= 1'b0;
         else if (evt_i[g])                  bit_q <= 1'b1;
         else if (clr_i[g] || clr_all_i)     bit_q <= 1'b0;
      end
      assign raw_o[g] = bit_q;

      // R2
      set_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
         evt_i[g] |=> raw_o[g]);
      // R5
      set_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
         (evt_i[g] && (clr_i[g] || clr_all_i)) |=> raw_o[g]);
      // R4
      clr_bit_chk: assert property (@(posedge clk) disable iff (!arst_n)
         ((clr_i[g] || clr_all_i) && !evt_i[g]) |=> !raw_o[g]);
      // R2
      rise_src_chk: assert property (@(posedge clk) disable iff (!arst_n)
         $rose(raw_o[g]) |-> $past(evt_i[g]));
   end
endmodule

// File: rtl/abort_cause_reg.sv
module abort_cause_reg #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         abort_evt_i,
   input  logic [W-1:0] cause_i,
   input  logic         wipe_i,
   output logic [W-1:0] cause_o,
   output logic         flush_o
);
   logic [W-1:0] cause_q;
   logic [W-1:0] fresh;
   logic         flush_q;

   assign fresh = abort_evt_i ? cause_i : '0;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cause_q <= '0;
         flush_q <= 1'b0;
      end else begin
         cause_q <= (wipe_i ? '0 : cause_q) | fresh;
         flush_q <= abort_evt_i;
      end
   end

   assign cause_o = cause_q;
   assign flush_o = flush_q;

   // R7
   no_stray_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!abort_evt_i && !wipe_i) |=> $stable(cause_o));
   // R8
   wipe_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (wipe_i && !abort_evt_i) |=> (cause_o == '0));
   // R9
   flush_on_chk: assert property (@(posedge clk) disable iff (!arst_n)
      abort_evt_i |=> flush_o);
   // R9
   flush_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !abort_evt_i |=> !flush_o);
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import i2cm_irq_pkg::*;
#(
   parameter int N      = 12,
   parameter int W      = 11,
   parameter int ADDR_W = 5,
   localparam int DW    = max2(N, W)
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [N-1:0]      wdata,
   input  logic [N-1:0]      raw_i,
   input  logic [W-1:0]      cause_i,
   output logic [N-1:0]      mask_o,
   output logic [DW-1:0]     rdata,
   output logic [N-1:0]      clr_o,
   output logic              clr_all_o,
   output logic              wipe_o
);
   logic [N-1:0]  mask_q;
   logic          mask_wr;
   logic [DW-1:0] rd_word;

   assign mask_wr = wr_en && (addr == ADDR_W'(ADR_MASK));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      mask_q <= '0;
      else if (mask_wr) mask_q <= wdata;
   end
   assign mask_o = mask_q;

   for (genvar g = 0; g < N; g++) begin : g_clr
      assign clr_o[g] = rd_en && (addr == ADDR_W'(ADR_CLR_BASE + g));
   end
   assign clr_all_o = rd_en && (addr == ADDR_W'(ADR_CLR_ALL));
   assign wipe_o    = clr_all_o || clr_o[SRC_TX_ABRT];

   always_comb begin
      rd_word = '0;
      if (rd_en) begin
         if (addr == ADDR_W'(ADR_MASK))         rd_word = DW'(mask_q);
         else if (addr == ADDR_W'(ADR_RAW))     rd_word = DW'(raw_i);
         else if (addr == ADDR_W'(ADR_MSTAT))   rd_word = DW'(raw_i & mask_q);
         else if (addr == ADDR_W'(ADR_CAUSE))   rd_word = DW'(cause_i);
         else if (addr == ADDR_W'(ADR_CLR_ALL)) rd_word = DW'(raw_i);
         for (int i = 0; i < N; i++) begin
            if (addr == ADDR_W'(ADR_CLR_BASE + i)) rd_word = DW'(raw_i[i]);
         end
      end
   end
   assign rdata = rd_word;

   // R3
   mask_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !mask_wr |=> $stable(mask_o));
   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !rd_en |-> (rdata == '0));
endmodule

// File: rtl/i2cm_irq_ctrl.sv
module i2cm_irq_ctrl
   import i2cm_irq_pkg::*;
#(
   parameter int NUM_SRC   = SRC_COUNT,
   parameter int NUM_CAUSE = CAUSE_COUNT,
   parameter int ADDR_W    = 5,
   parameter bit IRQ_REG   = 1'b1,
   localparam int DW       = max2(NUM_SRC, NUM_CAUSE)
) (
   input  logic                 clk,
   input  logic                 arst_n,
   input  logic [NUM_SRC-1:0]   evt_i,
   input  logic [NUM_CAUSE-1:0] abrt_cause_i,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_SRC-1:0]   wdata,
   output logic [DW-1:0]        rdata,
   output logic                 irq_o,
   output logic                 flush_o
);
   // elaboration-time parameter checks
   if (NUM_SRC <= SRC_TX_ABRT) begin : g_bad_src
      $error("NUM_SRC must cover the abort source bit");
   end
   if (NUM_CAUSE < 1) begin : g_bad_cause
      $error("NUM_CAUSE must be at least 1");
   end
   if (ADR_CLR_BASE + NUM_SRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the per-source clear addresses");
   end

   logic [NUM_SRC-1:0]   raw;
   logic [NUM_SRC-1:0]   mask;
   logic [NUM_SRC-1:0]   clr;
   logic                 clr_all;
   logic                 wipe;
   logic [NUM_CAUSE-1:0] cause;
   logic                 any_pend;

   irq_src_bank #(.N(NUM_SRC)) u_bank (
      .clk       (clk),
      .arst_n    (arst_n),
      .evt_i     (evt_i),
      .clr_i     (clr),
      .clr_all_i (clr_all),
      .raw_o     (raw)
   );

   abort_cause_reg #(.W(NUM_CAUSE)) u_cause (
      .clk         (clk),
      .arst_n      (arst_n),
      .abort_evt_i (evt_i[SRC_TX_ABRT]),
      .cause_i     (abrt_cause_i),
      .wipe_i      (wipe),
      .cause_o     (cause),
      .flush_o     (flush_o)
   );

   irq_reg_port #(.N(NUM_SRC), .W(NUM_CAUSE), .ADDR_W(ADDR_W)) u_port (
      .clk       (clk),
      .arst_n    (arst_n),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .raw_i     (raw),
      .cause_i   (cause),
      .mask_o    (mask),
      .rdata     (rdata),
      .clr_o     (clr),
      .clr_all_o (clr_all),
      .wipe_o    (wipe)
   );

   assign any_pend = |(raw & mask);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) irq_q <= 1'b0;
         else         irq_q <= any_pend;
      end
      assign irq_o = irq_q;

      // R10
      irq_follow_chk: assert property (@(posedge clk) disable iff (!arst_n)
         any_pend |=> irq_o);
      // R10
      irq_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
         !any_pend |=> !irq_o);
   end else begin : g_irq_comb
      assign irq_o = any_pend;
   end

   // R3
   mstat_view_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (rd_en && addr == ADDR_W'(ADR_MSTAT)) |-> (rdata == DW'(raw & mask)));
endmodule

// File: tb/sim_i2cm_irq_ctrl.sv
module sim_i2cm_irq_ctrl;
   localparam int NS = 12;
   localparam int NC = 11;
   localparam int AW = 5;
   localparam int DW = 12;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NS-1:0] evt = '0;
   logic [NC-1:0] cause = '0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NS-1:0] wdata = '0;
   wire  [DW-1:0] rdata;
   wire           irq;
   wire           flush;

   i2cm_irq_ctrl u0 (
      .clk(clk), .arst_n(arst_n), .evt_i(evt), .abrt_cause_i(cause),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_o(irq), .flush_o(flush)
   );

   int errors = 0;
   int checks = 0;

   // behavioural reference state
   logic [NS-1:0] m_raw = '0;
   logic [NS-1:0] m_mask = '0;
   logic [NC-1:0] m_cause = '0;
   logic          m_irq = 1'b0;
   logic          m_flush = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_rd(input logic r, input logic [AW-1:0] a);
      int ai = int'(a);
      if (!r) return '0;
      if (ai == 0) return DW'(m_mask);
      if (ai == 1) return DW'(m_raw);
      if (ai == 2) return DW'(m_raw & m_mask);
      if (ai == 3) return DW'(m_cause);
      if (ai == 4) return DW'(m_raw);
      if (ai >= 16 && ai < 16 + NS) return DW'(m_raw[ai-16]);
      return '0;
   endfunction

   task automatic cyc(input string tag, input logic [NS-1:0] e, input logic [NC-1:0] c,
                      input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [NS-1:0] d);
      logic [NS-1:0] nraw;
      logic [NC-1:0] ncause;
      int ai;
      evt = e; cause = c; rd_en = r; wr_en = w; addr = a; wdata = d;
      #2;
      chk({tag, " rdata"}, 32'(rdata), 32'(exp_rd(r, a)));
      @(posedge clk);
      ai = int'(a);
      nraw = m_raw;
      if (r && ai == 4) nraw = '0;
      if (r && ai >= 16 && ai < 16 + NS) nraw[ai-16] = 1'b0;
      nraw |= e;
      ncause = (r && (ai == 4 || ai == 23)) ? '0 : m_cause;
      if (e[7]) ncause |= c;
      m_irq = |(m_raw & m_mask);
      m_flush = e[7];
      if (w && ai == 0) m_mask = d;
      m_raw = nraw;
      m_cause = ncause;
      @(negedge clk);
      chk({tag, " irq"}, 32'(irq), 32'(m_irq));
      chk({tag, " flush"}, 32'(flush), 32'(m_flush));
   endtask

   task automatic rdc(input string tag, input logic [AW-1:0] a);
      cyc(tag, '0, '0, 1'b1, 1'b0, a, '0);
   endtask

   task automatic idle(input string tag);
      cyc(tag, '0, '0, 1'b0, 1'b0, '0, '0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 irq in reset", 32'(irq), 0);
      chk("R1 flush in reset", 32'(flush), 0);
      @(negedge clk);
      arst_n = 1'b1;
      // R1 reset state
      rdc("R1 mask", 0);
      rdc("R1 raw", 1);
      rdc("R1 cause", 3);
      // R2 events set sticky bits
      cyc("R2 set", 12'h021, '0, 0, 0, 0, 0);
      cyc("R2 set2", 12'h800, '0, 0, 0, 0, 0);
      idle("R2 hold");
      rdc("R2 raw", 1);
      // R11 unmapped address and idle read
      rdc("R11 unmapped", 5'd9);
      // R3 mask write, masked view; write elsewhere ignored
      cyc("R3 write mask", '0, '0, 0, 1, 0, 12'h801);
      rdc("R3 masked", 2);
      cyc("R3 stray write", '0, '0, 0, 1, 5'd1, 12'hfff);
      rdc("R3 mask kept", 0);
      idle("R10 irq");
      // R4 per-source clear of bit 0 only
      rdc("R4 clr bit0", 5'd16);
      rdc("R4 raw after", 1);
      rdc("R4 clr bit0 again", 5'd16);
      // R5 event and clear of bit 11 together
      cyc("R5 set wins", 12'h800, '0, 1, 0, 5'd27, 0);
      rdc("R5 raw", 1);
      // R6 global clear while bit 3 fires
      cyc("R6 global clear", 12'h008, '0, 1, 0, 5'd4, 0);
      rdc("R6 raw", 1);
      rdc("R6 clear bit3", 5'd19);
      // R7 abort cause accumulates, ignored without abort
      cyc("R7 cause no abort", '0, 11'h7ff, 0, 0, 0, 0);
      rdc("R7 cause ignored", 3);
      cyc("R9 abort1", 12'h080, 11'h012, 0, 0, 0, 0);
      cyc("R9 abort2", 12'h080, 11'h401, 0, 0, 0, 0);
      idle("R9 flush drop");
      rdc("R7 cause accum", 3);
      // R8 abort clear wipes cause
      rdc("R8 clr abort", 5'd23);
      rdc("R8 cause zero", 3);
      // R8 wipe in same cycle as new abort keeps fresh bits
      cyc("R9 abort3", 12'h080, 11'h004, 0, 0, 0, 0);
      cyc("R8 wipe and abort", 12'h080, 11'h100, 1, 0, 5'd23, 0);
      rdc("R8 fresh kept", 3);
      // R6 global clear wipes cause
      rdc("R6 global wipe", 5'd4);
      rdc("R6 cause zero", 3);
      // R10 interrupt with mask change
      cyc("R10 mask all", '0, '0, 0, 1, 0, 12'hfff);
      cyc("R10 event", 12'h040, '0, 0, 0, 0, 0);
      idle("R10 rise");
      rdc("R10 clear", 5'd22);
      idle("R10 fall");
      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [NS-1:0] e;
         e = ($urandom % 4 == 0) ? (NS'($urandom) & NS'($urandom)) : '0;
         cyc("R10 random", e, NC'($urandom), 1'($urandom), ($urandom % 8 == 0),
             AW'($urandom), NS'($urandom));
      end
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R1..: actual=timeout expected=done");
      summary();
      $finish;
   end
endmodule